// File: doc/BRIEF.md
# Exclusive-Access Monitored Word Memory

This block is a single-port memory organised as 32-bit words and addressed in bytes. It carries a monitor for exclusive access by one requester. Each request is one of four kinds: a plain load, a plain store, a load-exclusive or a store-exclusive. Each request has a byte, halfword or word size. Every request gets a response one cycle later. Loads return data zero-extended into the low bits of the result. Stores update only the byte lanes that the size and the low address bits select.

A load-exclusive reads its location and records a tag made of the address and the size. A later store-exclusive writes only when the monitor still holds a tag with the same address and the same size. The store-exclusive reports status 0 when it writes and 1 when it does not. Any store-exclusive leaves the monitor idle. Two further inputs also clear the monitor:
- a store seen on a separate observation port that lands in the tagged word;
- a clear pulse, as used at a context switch.

Top module: `excl_mem`

## Requirements
- R1: While reset is high, and on the first cycle after it, `rsp_valid`, `rsp_status` and `rsp_err` are 0 and the monitor is idle, so a store-exclusive issued right after reset fails with status 1.
- R2: Every request with `req_valid` high gets `rsp_valid` high on the next cycle, and an idle cycle gets `rsp_valid` low. Byte lanes are little-endian: the byte at offset n of a word is bits [8n+7:8n]. A halfword at offset 2 is bits [31:16]. Read results are zero-extended. Size code 0 is byte, 1 is halfword, 2 is word, and 3 behaves as word.
- R3: A plain store (`req_op` = 1) changes only the byte lanes covered by its size and offset. The other bytes of the word keep their values.
- R4: A load-exclusive (`req_op` = 2) returns the addressed data and arms the monitor. A following store-exclusive (`req_op` = 3) with the same address and size writes its data and returns status 0.
- R5: A store-exclusive that finds the monitor idle returns status 1 and leaves memory unchanged. `rsp_status` is 1 only in the response to a store-exclusive.
- R6: A store-exclusive fails with status 1 and leaves memory unchanged when its size differs from the tagged size or its byte address differs from the tagged address.
- R7: Every store-exclusive leaves the monitor idle, whether it succeeds or fails. A second store-exclusive without a new load-exclusive fails.
- R8: A new load-exclusive replaces the stored tag. Only the most recent address and size can succeed.
- R9: A pulse on `clr_excl`, or an observed store (`snoop_valid`) to any byte of the tagged word, clears the monitor. An observed store to a different word does not clear it.
- R10: A halfword at an odd address, or a word at an address that is not a multiple of four, is misaligned. A misaligned request sets `rsp_err`, writes nothing and reads 0. A misaligned store-exclusive returns status 1. A misaligned load-exclusive leaves the monitor unchanged.
- R11: A plain store from the requester itself, even to the tagged word, does not clear the monitor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 load, 1 store, 2 load-exclusive, 3 store-exclusive |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store data, right-justified |
| snoop_valid | input | 1 | Store by another agent observed this cycle |
| snoop_addr | input | ADDR_W | Byte address of the observed store |
| clr_excl | input | 1 | Clears the monitor |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Zero-extended load data, 0 for stores and errors |
| rsp_status | output | 1 | Store-exclusive result: 0 written, 1 not written |
| rsp_err | output | 1 | Misaligned request |

## Verification
The bench builds the block with `ADDR_W` = 6, which gives sixteen words. With that size, the word that was never written can be read back as zero after a rejected store, and the test addresses all fit in a short table. The width of the tag comparison shrinks with `ADDR_W`. The cases that matter do not depend on that width: the word, the in-word offset and the size all take part in each match.

// File: rtl/excl_mem_pkg.sv
package excl_mem_pkg;

  localparam int DATA_W = 32;
  localparam int NB     = DATA_W / 8;
  localparam int OFF_W  = $clog2(NB);

  typedef enum logic [1:0] {
    OP_LOAD     = 2'd0,
    OP_STORE    = 2'd1,
    OP_LOAD_EX  = 2'd2,
    OP_STORE_EX = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } size_e;

  // Size code 3 is folded onto the word size.
  function automatic logic [1:0] norm_size(input logic [1:0] sz);
    return (sz == SZ_WALT) ? SZ_WORD : sz;
  endfunction

  function automatic logic is_misaligned(input logic [1:0] sz, input logic [OFF_W-1:0] off);
    case (sz)
      SZ_BYTE: return 1'b0;
      SZ_HALF: return off[0];
      default: return |off;
    endcase
  endfunction

endpackage

// File: rtl/excl_mem_ram.sv
module excl_mem_ram #(
  parameter int WORDS  = 1024,
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       en,
  input  logic [DATA_W/8-1:0]        we,
  input  logic [$clog2(WORDS)-1:0]   addr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata
);
  localparam int NB = DATA_W / 8;

  logic [DATA_W-1:0] mem [WORDS];

  initial begin
    for (int i = 0; i < WORDS; i++) mem[i] = '0;
  end

  // Read-before-write, byte-enable write: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (en) begin
      for (int b = 0; b < NB; b++) begin
        if (we[b]) mem[addr][8*b +: 8] <= wdata[8*b +: 8];
      end
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/excl_mem_lanes.sv
module excl_mem_lanes
  import excl_mem_pkg::*;
(
  input  logic [1:0]        wr_size,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NB-1:0]     wr_be,
  output logic [DATA_W-1:0] wr_rep,
  input  logic [1:0]        rd_size,
  input  logic [OFF_W-1:0]  rd_off,
  input  logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] shifted;

  always_comb begin
    case (wr_size)
      SZ_BYTE: begin
        wr_be  = NB'(1) << wr_off;
        wr_rep = {NB{wr_data[7:0]}};
      end
      SZ_HALF: begin
        wr_be  = NB'(3) << wr_off;
        wr_rep = {(NB/2){wr_data[15:0]}};
      end
      default: begin
        wr_be  = '1;
        wr_rep = wr_data;
      end
    endcase
  end

  always_comb begin
    shifted = rd_word >> {rd_off, 3'b000};
    case (rd_size)
      SZ_BYTE: rd_data = DATA_W'(shifted[7:0]);
      SZ_HALF: rd_data = DATA_W'(shifted[15:0]);
      default: rd_data = rd_word;
    endcase
  end
endmodule

// File: rtl/excl_mem_monitor.sv
module excl_mem_monitor #(
  parameter int WORD_AW = 10,
  parameter int OFF_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               arm,
  input  logic [WORD_AW-1:0] arm_word,
  input  logic [OFF_W-1:0]   arm_off,
  input  logic [1:0]         arm_size,
  input  logic               sx,
  input  logic [WORD_AW-1:0] sx_word,
  input  logic [OFF_W-1:0]   sx_off,
  input  logic [1:0]         sx_size,
  input  logic               snoop_valid,
  input  logic [WORD_AW-1:0] snoop_word,
  input  logic               clr,
  output logic               pass,
  output logic               armed
);
  logic [WORD_AW-1:0] tag_word;
  logic [OFF_W-1:0]   tag_off;
  logic [1:0]         tag_size;
  logic               snoop_hit;

  assign snoop_hit = snoop_valid && armed && (snoop_word == tag_word);
  assign pass = armed && !clr && !snoop_hit &&
                (sx_word == tag_word) && (sx_off == tag_off) && (sx_size == tag_size);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      tag_word <= '0;
      tag_off  <= '0;
      tag_size <= '0;
    end else if (arm) begin
      armed    <= 1'b1;
      tag_word <= arm_word;
      tag_off  <= arm_off;
      tag_size <= arm_size;
    end else if (sx || clr || snoop_hit) begin
      armed <= 1'b0;
    end
  end
endmodule

// File: rtl/excl_mem.sv
module excl_mem
  import excl_mem_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              clr_excl,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_status,
  output logic              rsp_err
);
  localparam int WORD_AW = ADDR_W - OFF_W;
  localparam int WORDS   = 1 << WORD_AW;

  logic [WORD_AW-1:0] word;
  logic [OFF_W-1:0]   off;
  logic [1:0]         sz;
  logic               mis, is_st, is_lx, is_sx, is_rd, pass, armed, do_wr;
  logic [NB-1:0]      be;
  logic [DATA_W-1:0]  wrep, ram_q, rd_ext;

  logic               rd_q, err_q, status_q, valid_q;
  logic [1:0]         size_q;
  logic [OFF_W-1:0]   off_q;

  assign word  = req_addr[ADDR_W-1:OFF_W];
  assign off   = req_addr[OFF_W-1:0];
  assign sz    = norm_size(req_size);
  assign mis   = is_misaligned(sz, off);
  assign is_st = req_valid && (req_op == OP_STORE);
  assign is_lx = req_valid && (req_op == OP_LOAD_EX);
  assign is_sx = req_valid && (req_op == OP_STORE_EX);
  assign is_rd = req_valid && !req_op[0];
  assign do_wr = !mis && (is_st || (is_sx && pass));

  excl_mem_lanes u_lanes (
    .wr_size (sz),
    .wr_off  (off),
    .wr_data (req_wdata),
    .wr_be   (be),
    .wr_rep  (wrep),
    .rd_size (size_q),
    .rd_off  (off_q),
    .rd_word (ram_q),
    .rd_data (rd_ext)
  );

  excl_mem_ram #(.WORDS(WORDS), .DATA_W(DATA_W)) u_ram (
    .clk   (clk),
    .en    (req_valid),
    .we    (do_wr ? be : '0),
    .addr  (word),
    .wdata (wrep),
    .rdata (ram_q)
  );

  excl_mem_monitor #(.WORD_AW(WORD_AW), .OFF_W(OFF_W)) u_mon (
    .clk         (clk),
    .rst         (rst),
    .arm         (is_lx && !mis),
    .arm_word    (word),
    .arm_off     (off),
    .arm_size    (sz),
    .sx          (is_sx),
    .sx_word     (word),
    .sx_off      (off),
    .sx_size     (sz),
    .snoop_valid (snoop_valid),
    .snoop_word  (snoop_addr[ADDR_W-1:OFF_W]),
    .clr         (clr_excl),
    .pass        (pass),
    .armed       (armed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= 1'b0;
      rd_q     <= 1'b0;
      err_q    <= 1'b0;
      status_q <= 1'b0;
      size_q   <= '0;
      off_q    <= '0;
    end else begin
      valid_q  <= req_valid;
      rd_q     <= is_rd && !mis;
      err_q    <= req_valid && mis;
      status_q <= is_sx && !(pass && !mis);
      size_q   <= sz;
      off_q    <= off;
    end
  end

  assign rsp_valid  = valid_q;
  assign rsp_err    = err_q;
  assign rsp_status = status_q;
  assign rsp_rdata  = rd_q ? rd_ext : '0;
endmodule

// File: rtl/excl_mem_chk.sv
module excl_mem_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [1:0]        req_op,
  input logic [1:0]        req_size,
  input logic [ADDR_W-1:0] req_addr,
  input logic              clr_excl,
  input logic              rsp_valid,
  input logic              rsp_status,
  input logic              rsp_err,
  input logic              mon_armed
);
  logic bad_align;
  assign bad_align = (req_size == 2'd1) ? req_addr[0] :
                     (req_size[1])      ? |req_addr[1:0] : 1'b0;

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !mon_armed && !rsp_valid && !rsp_status); // R1
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst) req_valid |=> rsp_valid); // R2
  AST_NO_RSP_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst) !req_valid |=> !rsp_valid); // R2
  AST_LX_ARMS: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_op == 2'd2 && !bad_align |=> mon_armed); // R4
  AST_SX_IDLE_FAILS: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_op == 2'd3 && !mon_armed |=> rsp_status); // R5
  AST_STATUS_ONLY_SX: assert property (@(posedge clk) disable iff (rst)
    rsp_status |-> $past(req_valid && req_op == 2'd3)); // R5
  AST_SX_DISARMS: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_op == 2'd3 |=> !mon_armed); // R7
  AST_CLR_DISARMS: assert property (@(posedge clk) disable iff (rst)
    clr_excl && !(req_valid && req_op == 2'd2) |=> !mon_armed); // R9
  AST_MISALIGN_FLAG: assert property (@(posedge clk) disable iff (rst)
    req_valid && bad_align |=> rsp_err); // R10
  AST_ALIGNED_NO_ERR: assert property (@(posedge clk) disable iff (rst)
    req_valid && !bad_align |=> !rsp_err); // R10
  AST_MISALIGN_SX_FAILS: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_op == 2'd3 && bad_align |=> rsp_status); // R10
endmodule

bind excl_mem excl_mem_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_op     (req_op),
  .req_size   (req_size),
  .req_addr   (req_addr),
  .clr_excl   (clr_excl),
  .rsp_valid  (rsp_valid),
  .rsp_status (rsp_status),
  .rsp_err    (rsp_err),
  .mon_armed  (u_mon.armed)
);

// File: tb/excl_mem_tb.sv
module excl_mem_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  sz;
    logic [7:0]  addr;
    logic [31:0] wd;
    logic [31:0] rd;
    logic        st;
    logic        er;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 37;
  // op: 0 LD 1 ST 2 LX 3 SX ; sz: 0 B 1 H 2 W
  localparam vec_t VEC [NV] = '{
    '{2'd1, 2'd2, 8'h04, 32'h44332211, 32'h0,        1'b0, 1'b0, 8'd3},  // R3
    '{2'd0, 2'd0, 8'h04, 32'h0,        32'h11,       1'b0, 1'b0, 8'd2},  // R2
    '{2'd0, 2'd0, 8'h07, 32'h0,        32'h44,       1'b0, 1'b0, 8'd2},  // R2
    '{2'd0, 2'd1, 8'h06, 32'h0,        32'h4433,     1'b0, 1'b0, 8'd2},  // R2
    '{2'd1, 2'd0, 8'h05, 32'hAA,       32'h0,        1'b0, 1'b0, 8'd3},  // R3
    '{2'd0, 2'd2, 8'h04, 32'h0,        32'h4433AA11, 1'b0, 1'b0, 8'd3},  // R3
    '{2'd1, 2'd1, 8'h06, 32'hBEEF,     32'h0,        1'b0, 1'b0, 8'd3},  // R3
    '{2'd0, 2'd2, 8'h04, 32'h0,        32'hBEEFAA11, 1'b0, 1'b0, 8'd3},  // R3
    '{2'd3, 2'd2, 8'h04, 32'h12345678, 32'h0,        1'b1, 1'b0, 8'd5},  // R5
    '{2'd0, 2'd2, 8'h04, 32'h0,        32'hBEEFAA11, 1'b0, 1'b0, 8'd5},  // R5
    '{2'd2, 2'd2, 8'h04, 32'h0,        32'hBEEFAA11, 1'b0, 1'b0, 8'd4},  // R4
    '{2'd3, 2'd2, 8'h04, 32'h12345678, 32'h0,        1'b0, 1'b0, 8'd4},  // R4
    '{2'd0, 2'd2, 8'h04, 32'h0,        32'h12345678, 1'b0, 1'b0, 8'd4},  // R4
    '{2'd3, 2'd2, 8'h04, 32'hFFFFFFFF, 32'h0,        1'b1, 1'b0, 8'd7},  // R7
    '{2'd0, 2'd2, 8'h04, 32'h0,        32'h12345678, 1'b0, 1'b0, 8'd7},  // R7
    '{2'd2, 2'd1, 8'h04, 32'h0,        32'h5678,     1'b0, 1'b0, 8'd6},  // R6
    '{2'd3, 2'd2, 8'h04, 32'h0,        32'h0,        1'b1, 1'b0, 8'd6},  // R6 size
    '{2'd0, 2'd2, 8'h04, 32'h0,        32'h12345678, 1'b0, 1'b0, 8'd6},  // R6
    '{2'd2, 2'd0, 8'h05, 32'h0,        32'h56,       1'b0, 1'b0, 8'd6},  // R6
    '{2'd3, 2'd0, 8'h06, 32'h99,       32'h0,        1'b1, 1'b0, 8'd6},  // R6 address
    '{2'd0, 2'd2, 8'h04, 32'h0,        32'h12345678, 1'b0, 1'b0, 8'd6},  // R6
    '{2'd2, 2'd0, 8'h05, 32'h0,        32'h56,       1'b0, 1'b0, 8'd8},  // R8
    '{2'd2, 2'd1, 8'h08, 32'h0,        32'h0,        1'b0, 1'b0, 8'd8},  // R8
    '{2'd3, 2'd0, 8'h05, 32'h99,       32'h0,        1'b1, 1'b0, 8'd8},  // R8
    '{2'd2, 2'd1, 8'h0A, 32'h0,        32'h0,        1'b0, 1'b0, 8'd11}, // R11
    '{2'd1, 2'd0, 8'h08, 32'h77,       32'h0,        1'b0, 1'b0, 8'd11}, // R11
    '{2'd3, 2'd1, 8'h0A, 32'hABCD,     32'h0,        1'b0, 1'b0, 8'd11}, // R11
    '{2'd0, 2'd2, 8'h08, 32'h0,        32'hABCD0077, 1'b0, 1'b0, 8'd11}, // R11
    '{2'd2, 2'd2, 8'h08, 32'h0,        32'hABCD0077, 1'b0, 1'b0, 8'd10}, // R10
    '{2'd2, 2'd1, 8'h09, 32'h0,        32'h0,        1'b0, 1'b1, 8'd10}, // R10
    '{2'd3, 2'd2, 8'h08, 32'h01020304, 32'h0,        1'b0, 1'b0, 8'd10}, // R10
    '{2'd0, 2'd2, 8'h08, 32'h0,        32'h01020304, 1'b0, 1'b0, 8'd10}, // R10
    '{2'd3, 2'd1, 8'h0B, 32'h5555,     32'h0,        1'b1, 1'b1, 8'd10}, // R10
    '{2'd1, 2'd2, 8'h0D, 32'hFFFFFFFF, 32'h0,        1'b0, 1'b1, 8'd10}, // R10
    '{2'd0, 2'd2, 8'h0C, 32'h0,        32'h0,        1'b0, 1'b0, 8'd10}, // R10
    '{2'd0, 2'd1, 8'h03, 32'h0,        32'h0,        1'b0, 1'b1, 8'd10}, // R10
    '{2'd0, 2'd3, 8'h04, 32'h0,        32'h12345678, 1'b0, 1'b0, 8'd2}   // R2 size 3
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_op = '0, req_size = '0;
  logic [AW-1:0] req_addr = '0, snoop_addr = '0;
  logic [31:0] req_wdata = '0;
  logic snoop_valid = 1'b0, clr_excl = 1'b0;
  logic rsp_valid, rsp_status, rsp_err;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  excl_mem #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .clr_excl(clr_excl),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_status(rsp_status),
    .rsp_err(rsp_err)
  );

  task automatic req(input logic [1:0] op, input logic [1:0] sz, input logic [7:0] a,
                     input logic [31:0] wd, input logic [31:0] erd, input logic est,
                     input logic eer, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_size = sz; req_addr = a[AW-1:0]; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    checks++;
    if (rsp_valid !== 1'b1 || rsp_rdata !== erd || rsp_status !== est || rsp_err !== eer) begin
      fails++;
      $display("FAIL %s op=%0d addr=%h: got v=%b rd=%h st=%b er=%b exp v=1 rd=%h st=%b er=%b",
               tag, op, a, rsp_valid, rsp_rdata, rsp_status, rsp_err, erd, est, eer);
    end
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr_excl = 1'b1;
    @(negedge clk); clr_excl = 1'b0;
  endtask

  task automatic pulse_snoop(input logic [7:0] a);
    @(negedge clk); snoop_valid = 1'b1; snoop_addr = a[AW-1:0];
    @(negedge clk); snoop_valid = 1'b0;
  endtask

  task automatic check_idle(input string tag);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_status !== 1'b0 || rsp_err !== 1'b0) begin
      fails++;
      $display("FAIL %s idle response: got v=%b st=%b er=%b exp v=0 st=0 er=0",
               tag, rsp_valid, rsp_status, rsp_err);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_idle("R1 during reset");
    rst = 1'b0;
    @(negedge clk);
    check_idle("R1 after reset");
    req(2'd3, 2'd2, 8'h10, 32'h1, 32'h0, 1'b1, 1'b0, "R1 store-excl after reset");

    for (int i = 0; i < NV; i++) begin
      req(VEC[i].op, VEC[i].sz, VEC[i].addr, VEC[i].wd, VEC[i].rd, VEC[i].st, VEC[i].er,
          $sformatf("R%0d row %0d", VEC[i].req, i));
    end

    // R9: clear pulse
    req(2'd2, 2'd2, 8'h10, 32'h0, 32'h0, 1'b0, 1'b0, "R9 arm");
    pulse_clr();
    req(2'd3, 2'd2, 8'h10, 32'hDEAD, 32'h0, 1'b1, 1'b0, "R9 after clear");
    req(2'd0, 2'd2, 8'h10, 32'h0, 32'h0, 1'b0, 1'b0, "R9 no write after clear");
    // R9: observed store to tagged word
    req(2'd2, 2'd2, 8'h10, 32'h0, 32'h0, 1'b0, 1'b0, "R9 arm");
    pulse_snoop(8'h13);
    req(2'd3, 2'd2, 8'h10, 32'hDEAD, 32'h0, 1'b1, 1'b0, "R9 snoop same word");
    // R9: observed store elsewhere
    req(2'd2, 2'd2, 8'h10, 32'h0, 32'h0, 1'b0, 1'b0, "R9 arm");
    pulse_snoop(8'h14);
    req(2'd3, 2'd2, 8'h10, 32'h5A, 32'h0, 1'b0, 1'b0, "R9 snoop other word");
    req(2'd0, 2'd2, 8'h10, 32'h0, 32'h5A, 1'b0, 1'b0, "R9 write landed");
    @(negedge clk);
    check_idle("R2 idle cycle");

    // R1: reset in mid-flight drops the tag
    req(2'd2, 2'd2, 8'h10, 32'h0, 32'h5A, 1'b0, 1'b0, "R1 arm");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check_idle("R1 after second reset");
    req(2'd3, 2'd2, 8'h10, 32'h77, 32'h0, 1'b1, 1'b0, "R1 tag lost on reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule